// File: doc/BRIEF.md
# Mailbox Interrupt Flags for a Two-Port Shared Memory

This block produces the doorbell interrupts of a memory shared by two ports, called left and right. It watches the enable, write strobe and address of each port as the accesses go to the memory array. The array itself is outside this block. The two highest word addresses are reserved as one-way mailboxes, one for each direction.

A port rings the other side by writing to the mailbox that the other side owns:

- The left port sends through the top address (all ones).
- The right port sends through the address just below it (all ones except bit 0).

The receiving port's active-low interrupt output goes low and stays low. The receiving port clears it by reading its own mailbox address. No other command exists: setting and clearing happen only as side effects of ordinary memory traffic.

The address width is a parameter, and both mailbox addresses follow from it. Accesses are sampled on the rising clock edge. Each interrupt output comes straight from a flop and changes one edge after the access that affects it.

Top module: `mbx_int_flags`

## Requirements
- R1: While reset (rst_n low) is applied, and on the first cycle after it is released, both lft_int_n and rgt_int_n are high.
- R2: An enabled left write (lft_en=1, lft_we=1) to address all-ones (0xFFF for ADDR_W=12) drives rgt_int_n low after the next rising edge.
- R3: An enabled right read (rgt_en=1, rgt_we=0) of address all-ones drives rgt_int_n high after the next rising edge, unless a setting write happens in the same cycle.
- R4: An enabled right write to address all-ones-minus-one (0xFFE for ADDR_W=12) drives lft_int_n low after the next rising edge.
- R5: An enabled left read of address all-ones-minus-one drives lft_int_n high after the next rising edge, unless a setting write happens in the same cycle.
- R6: An access with its enable low never changes either interrupt output, whatever its write strobe and address.
- R7: An access that matches no rule above leaves both outputs unchanged. This covers other addresses, a read by the sending port, and a write by the receiving port to its own mailbox.
- R8: If a set and a clear of the same flag come in one cycle, the flag ends up set (output low).
- R9: A flag keeps its value on every cycle that brings it neither a set nor a clear. A set that comes while the flag is already set keeps it set.
- R10: The two mailbox addresses come from ADDR_W: 2^ADDR_W-1 belongs to the right port's flag and 2^ADDR_W-2 to the left port's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; accesses are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lft_en | input | 1 | Left port access enable |
| lft_we | input | 1 | Left port write strobe (1 = write, 0 = read) |
| lft_addr | input | ADDR_W | Left port word address |
| rgt_en | input | 1 | Right port access enable |
| rgt_we | input | 1 | Right port write strobe (1 = write, 0 = read) |
| rgt_addr | input | ADDR_W | Right port word address |
| lft_int_n | output | 1 | Left port interrupt, active low |
| rgt_int_n | output | 1 | Right port interrupt, active low |

## Verification
On every cycle out of reset, the assertions check the one-edge response of each flag to a setting write and to a clearing read. They also check that the set wins when both come together, and that a flag stays stable on any cycle with neither event. Together these cover disabled and non-matching accesses. Only the bench scenarios can show the value during and right after reset, and that flags persist across long sequences. They also show that the mailbox addresses are the exact values the default width gives, and that the two directions act independently when both ports ring at once.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int NUM_PORTS = 2;
    localparam int PORT_LFT  = 0;
    localparam int PORT_RGT  = 1;

    // Registered pending flag of each receiving port, 1 = interrupt raised
    typedef struct packed {
        logic [NUM_PORTS-1:0] pend;
    } mbx_state_t;

    // Per-port decode result
    typedef struct packed {
        logic send;   // write to the mailbox owned by the peer
        logic recv;   // read of the mailbox owned by this port
    } mbx_hit_t;

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter bit OUT_IS_HI = 1'b1
) (
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output mbx_hit_t          hit
);
    localparam logic [ADDR_W-1:0] ADDR_HI  = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] ADDR_LO  = {{(ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [ADDR_W-1:0] SEND_ADR = OUT_IS_HI ? ADDR_HI : ADDR_LO;
    localparam logic [ADDR_W-1:0] RECV_ADR = OUT_IS_HI ? ADDR_LO : ADDR_HI;

    always_comb begin
        hit      = '0;
        hit.send = en &&  we && (addr == SEND_ADR);
        hit.recv = en && !we && (addr == RECV_ADR);
    end

endmodule

// File: rtl/mbx_flag_next.sv
module mbx_flag_next (
    input  logic cur_q,
    input  logic set_i,
    input  logic clr_i,
    output logic nxt_d
);
    always_comb begin
        nxt_d = cur_q;
        if (clr_i) nxt_d = 1'b0;
        if (set_i) nxt_d = 1'b1;   // set has priority over clear
    end

endmodule

// File: rtl/mbx_int_flags.sv
module mbx_int_flags
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lft_en,
    input  logic              lft_we,
    input  logic [ADDR_W-1:0] lft_addr,
    input  logic              rgt_en,
    input  logic              rgt_we,
    input  logic [ADDR_W-1:0] rgt_addr,
    output logic              lft_int_n,
    output logic              rgt_int_n
);
    logic [NUM_PORTS-1:0]  en_v;
    logic [NUM_PORTS-1:0]  we_v;
    logic [ADDR_W-1:0]     addr_v [NUM_PORTS];
    mbx_hit_t              hit_v  [NUM_PORTS];
    logic [NUM_PORTS-1:0]  pend_nxt;
    mbx_state_t            state_d, state_q;

    assign en_v[PORT_LFT]   = lft_en;
    assign en_v[PORT_RGT]   = rgt_en;
    assign we_v[PORT_LFT]   = lft_we;
    assign we_v[PORT_RGT]   = rgt_we;
    assign addr_v[PORT_LFT] = lft_addr;
    assign addr_v[PORT_RGT] = rgt_addr;

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        // Left sends through the top word, right through the one below
        mbx_port_decode #(
            .ADDR_W    (ADDR_W),
            .OUT_IS_HI (g == PORT_LFT)
        ) u_dec (
            .en   (en_v[g]),
            .we   (we_v[g]),
            .addr (addr_v[g]),
            .hit  (hit_v[g])
        );

        // Flag g belongs to the receiving port g; the peer sets it
        mbx_flag_next u_nxt (
            .cur_q (state_q.pend[g]),
            .set_i (hit_v[NUM_PORTS-1-g].send),
            .clr_i (hit_v[g].recv),
            .nxt_d (pend_nxt[g])
        );
    end

    always_comb begin
        state_d      = state_q;
        state_d.pend = pend_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign lft_int_n = ~state_q.pend[PORT_LFT];
    assign rgt_int_n = ~state_q.pend[PORT_RGT];

endmodule

// File: rtl/mbx_int_flags_chk.sv
module mbx_int_flags_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lft_en,
    input logic              lft_we,
    input logic [ADDR_W-1:0] lft_addr,
    input logic              rgt_en,
    input logic              rgt_we,
    input logic [ADDR_W-1:0] rgt_addr,
    input logic              lft_int_n,
    input logic              rgt_int_n
);
    localparam logic [ADDR_W-1:0] TOP_W = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] SUB_W = TOP_W - 1'b1;

    logic rgt_set, rgt_clr, lft_set, lft_clr;
    assign rgt_set = lft_en &&  lft_we && (lft_addr == TOP_W);
    assign rgt_clr = rgt_en && !rgt_we && (rgt_addr == TOP_W);
    assign lft_set = rgt_en &&  rgt_we && (rgt_addr == SUB_W);
    assign lft_clr = lft_en && !lft_we && (lft_addr == SUB_W);

    AST_RGT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        rgt_set |=> !rgt_int_n);                                   // R2
    AST_RGT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rgt_clr && !rgt_set) |=> rgt_int_n);                      // R3
    AST_LFT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        lft_set |=> !lft_int_n);                                   // R4
    AST_LFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (lft_clr && !lft_set) |=> lft_int_n);                      // R5
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rgt_set && rgt_clr) || (lft_set && lft_clr) |=>
        (!(rgt_set && rgt_clr) || !rgt_int_n) || (!lft_int_n));    // R8
    AST_RGT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rgt_set && !rgt_clr) |=> $stable(rgt_int_n));            // R9
    AST_LFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!lft_set && !lft_clr) |=> $stable(lft_int_n));            // R9

endmodule

bind mbx_int_flags mbx_int_flags_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lft_en    (lft_en),
    .lft_we    (lft_we),
    .lft_addr  (lft_addr),
    .rgt_en    (rgt_en),
    .rgt_we    (rgt_we),
    .rgt_addr  (rgt_addr),
    .lft_int_n (lft_int_n),
    .rgt_int_n (rgt_int_n)
);

// File: tb/tb_mbx_int_flags.sv
module tb_mbx_int_flags;
    localparam int ADDR_W = 12;
    localparam logic [ADDR_W-1:0] A_TOP = 12'hFFF;   // R10
    localparam logic [ADDR_W-1:0] A_SUB = 12'hFFE;   // R10

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lft_en = 1'b0, lft_we = 1'b0, rgt_en = 1'b0, rgt_we = 1'b0;
    logic [ADDR_W-1:0] lft_addr = '0, rgt_addr = '0;
    logic lft_int_n, rgt_int_n;

    always #10 clk = ~clk;   // 50 MHz

    mbx_int_flags #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .lft_en(lft_en), .lft_we(lft_we), .lft_addr(lft_addr),
        .rgt_en(rgt_en), .rgt_we(rgt_we), .rgt_addr(rgt_addr),
        .lft_int_n(lft_int_n), .rgt_int_n(rgt_int_n)
    );

    typedef struct {
        logic  lft;
        logic  rgt;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   m_lft = 1'b0;   // model: pending flags
    bit   m_rgt = 1'b0;
    bit   done  = 1'b0;

    // Driver: apply one cycle, update model, push expected outputs
    task automatic step(input logic le, input logic lw, input logic [ADDR_W-1:0] la,
                        input logic re, input logic rw, input logic [ADDR_W-1:0] ra,
                        input string tag);
        exp_t e;
        bit rs, rc, ls, lc;
        @(negedge clk);
        lft_en = le; lft_we = lw; lft_addr = la;
        rgt_en = re; rgt_we = rw; rgt_addr = ra;
        rs = le &&  lw && (la == A_TOP);
        rc = re && !rw && (ra == A_TOP);
        ls = re &&  rw && (ra == A_SUB);
        lc = le && !lw && (la == A_SUB);
        if (rs) m_rgt = 1'b1; else if (rc) m_rgt = 1'b0;
        if (ls) m_lft = 1'b1; else if (lc) m_lft = 1'b0;
        @(posedge clk);
        #1;
        e.lft = ~m_lft; e.rgt = ~m_rgt; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic apply_reset(input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = 1'b0;
        lft_en = 1'b0; rgt_en = 1'b0;
        m_lft = 1'b0; m_rgt = 1'b0;
        @(posedge clk);
        #1;
        e.lft = 1'b1; e.rgt = 1'b1; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: compare at the falling edge after the registering edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_cmp++;
            if (lft_int_n !== e.lft || rgt_int_n !== e.rgt) begin
                n_bad++;
                $display("FAIL %s: lft_int_n/rgt_int_n actual %b%b expected %b%b",
                         e.tag, lft_int_n, rgt_int_n, e.lft, e.rgt);
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        apply_reset("R1 in reset");
        step(0,0,'0, 0,0,'0, "R1 after release");
        step(1,1,A_TOP, 0,0,'0, "R2 R10 left writes 0xFFF");
        step(1,0,A_TOP, 0,0,'0, "R7 sender reads its own send address");
        step(0,0,'0, 1,1,A_TOP, "R7 receiver writes its mailbox");
        step(0,0,'0, 1,0,A_SUB, "R7 right reads other mailbox");
        step(0,0,'0, 0,0,A_TOP, "R6 disabled right read of 0xFFF");
        step(0,0,'0, 1,0,A_TOP, "R3 right reads 0xFFF");
        step(0,0,'0, 1,1,A_SUB, "R4 R10 right writes 0xFFE");
        step(0,0,'0, 1,1,A_SUB, "R9 repeated set holds");
        step(0,0,'0, 0,0,'0,    "R9 idle holds");
        step(1,0,12'h7FE, 0,0,'0, "R7 left reads unrelated address");
        step(1,0,A_SUB, 0,0,'0, "R5 left reads 0xFFE");
        step(1,1,12'hFFD, 0,0,'0, "R7 left writes 0xFFD");
        step(0,1,A_TOP, 0,0,'0, "R6 disabled left write of 0xFFF");
        step(1,1,A_TOP, 1,0,A_TOP, "R8 set and clear together on right");
        step(0,0,'0, 1,0,A_TOP, "R3 clear after collision");
        step(1,0,A_SUB, 1,1,A_SUB, "R8 set and clear together on left");
        step(1,1,A_TOP, 0,0,'0, "R2 both flags raised");
        step(0,0,'0, 0,1,A_SUB, "R6 disabled right write keeps state");
        apply_reset("R1 reset clears raised flags");
        step(0,0,'0, 0,0,'0, "R1 after second release");
        step(1,1,A_TOP, 1,1,A_SUB, "R2 R4 both ports ring at once");
        step(1,0,A_SUB, 1,0,A_TOP, "R3 R5 both ports clear at once");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule